// File: doc/BRIEF.md
# I2C Control-Register Target

This block is the serial control port of a signal-processing chip. An external controller reaches a file of 32 eight-bit control registers over a two-wire I2C bus. The block recognises its own 7-bit device address. In a write it takes a subaddress byte that selects a register and sets two flags, and then stores the data bytes that follow. In a read it returns a status byte built from live flags supplied by neighbouring blocks. That byte is captured again after every byte the controller acknowledges, so a controller can poll by clocking more bytes without sending the address again.

The register contents are presented in parallel on a flat output bus. Each register has a one-cycle write strobe, so downstream logic can react to a write even when the value does not change. Two side functions come from the same register traffic:

- An input fast-charge enable is high from reset until the first write to register 0, and is then released.
- A test enable is raised only when the most recent subaddress carried the test flag and bit 0 of the first test register is set.

SCL and SDA are sampled by the system clock through synchronisers. START and STOP are recognised anywhere in a transfer.

Top module: `ctl_i2c_target`

## Requirements
- R1: The block acknowledges an address byte whose upper seven bits equal 7'b1000100. Bit 0 of that byte selects the direction: 0 for write, 1 for read. For any other address the block leaves SDA released for the rest of the transfer and changes no register.
- R2: The first byte after a write address is the subaddress. Bit 7 is the test flag, bit 6 is ignored, bit 5 enables auto-increment, and bits 4..0 select the register. Each following data byte is acknowledged and stored into the selected register. The register file is presented on `regs_o`, with register n on bits [8n+7:8n].
- R3: With auto-increment set, the register index advances by one after each data byte and wraps from 31 to 0.
- R4: With auto-increment clear, every data byte of a transfer is written to the same register, so the last byte is the one kept. Neighbouring registers are not touched.
- R5: Every stored data byte raises `wr_stb_o[n]` of its register n for exactly one clock cycle. At most one strobe bit is high at any time.
- R6: After reset, registers 27 to 31 hold 8'hFE and all other registers hold 8'h00. A register keeps its value until a data byte is written to it.
- R7: `fast_chg_o` is 1 after reset and falls once a data byte has been written to register 0. It does not rise again before the next reset.
- R8: After a read address, the block sends the status byte MSB first. The byte is {2'b00, stat_i[5:0]}, where stat_i[5] is the soft-step busy flag (0 = busy), stat_i[4] is main mute, stat_i[3] is sub mute, and stat_i[2:0] are speaker 2..0 mute. The byte is captured when the previous acknowledge ends. A controller ACK starts another captured byte; a NACK ends the transfer with SDA released.
- R9: `test_en_o` equals the test flag of the latest subaddress AND bit 0 of register 27.
- R10: A STOP releases SDA and ends the transfer. A repeated START begins a new address phase. The port works with an SCL bit period of 120 system clocks, which is faster than 400 kHz at a 100 MHz system clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | I2C clock line as seen at the pad |
| sda_i | input | 1 | I2C data line as seen at the pad |
| sda_oe | output | 1 | 1 pulls SDA low (open drain) |
| stat_i | input | 6 | Live status flags returned in reads |
| regs_o | output | 256 | All 32 registers, register n at [8n+7:8n] |
| wr_stb_o | output | 32 | One-cycle write strobe per register |
| fast_chg_o | output | 1 | Input fast-charge switch enable |
| test_en_o | output | 1 | Test functions enabled |

## Verification
A wrong byte counter or a wrong phase state shows on the bus within one byte. It appears as a missing or misplaced acknowledge, or as a status bit shifted by one position. A wrong register index after auto-increment or wrap shows on `regs_o` and on the strobe bus in the cycle after the data byte's acknowledge begins. A fast-charge or test-flag latch that is stale shows as a wrong level on its own output as soon as the related write completes. The directed cases cover the wrap from 31 to 0, a status change in the middle of a read, and a foreign address followed by a data byte aimed at register 0.

// File: rtl/ctl_i2c_pkg.sv
package ctl_i2c_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RX,
    ST_RX_ACK,
    ST_TX,
    ST_TX_ACK
  } bus_state_t;

  typedef enum logic [1:0] {
    BY_ADDR,
    BY_SUB,
    BY_DATA
  } byte_kind_t;

  // Power-on value of a control register: test bank pre-loaded, rest cleared
  function automatic logic [7:0] reg_reset_value(input int idx, input int test_base);
    return (idx >= test_base) ? 8'hFE : 8'h00;
  endfunction

endpackage

// File: rtl/ctl_i2c_sync.sv
module ctl_i2c_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_q,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [STAGES-1:0] scl_pipe, sda_pipe;
  logic scl_d, sda_d, scl_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_pipe <= '1;
      sda_pipe <= '1;
      scl_d    <= 1'b1;
      sda_d    <= 1'b1;
    end else begin
      scl_pipe <= {scl_pipe[STAGES-2:0], scl_i};
      sda_pipe <= {sda_pipe[STAGES-2:0], sda_i};
      scl_d    <= scl_pipe[STAGES-1];
      sda_d    <= sda_pipe[STAGES-1];
    end
  end

  always_comb begin
    scl_q     = scl_pipe[STAGES-1];
    sda_q     = sda_pipe[STAGES-1];
    scl_rise  = scl_q & ~scl_d;
    scl_fall  = ~scl_q & scl_d;
    start_det = scl_q & scl_d & sda_d & ~sda_q;
    stop_det  = scl_q & scl_d & ~sda_d & sda_q;
  end

endmodule

// File: rtl/ctl_i2c_engine.sv
module ctl_i2c_engine
  import ctl_i2c_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'b1000100,
  parameter int         IDX_W    = 5,
  parameter int         STAT_W   = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sda_q,
  input  logic             scl_rise,
  input  logic             scl_fall,
  input  logic             start_det,
  input  logic             stop_det,
  input  logic [STAT_W-1:0] stat_i,
  output logic             sda_oe,
  output logic             wr_en,
  output logic [IDX_W-1:0] wr_idx,
  output logic [7:0]       wr_data,
  output logic             test_flag
);
  localparam int PAD_W = 8 - STAT_W;

  bus_state_t       st;
  byte_kind_t       kind;
  logic [3:0]       cnt;
  logic [7:0]       sh;
  logic [7:0]       tx;
  logic             rw;
  logic             ai;
  logic             nack;
  logic [IDX_W-1:0] idx;
  logic [7:0]       status_byte;

  always_comb status_byte = {{PAD_W{1'b0}}, stat_i};

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= ST_IDLE;
      kind      <= BY_ADDR;
      cnt       <= '0;
      sh        <= '0;
      tx        <= '0;
      rw        <= 1'b0;
      ai        <= 1'b0;
      nack      <= 1'b1;
      idx       <= '0;
      sda_oe    <= 1'b0;
      wr_en     <= 1'b0;
      wr_idx    <= '0;
      wr_data   <= '0;
      test_flag <= 1'b0;
    end else begin
      wr_en <= 1'b0;
      if (start_det) begin
        st     <= ST_RX;
        kind   <= BY_ADDR;
        cnt    <= '0;
        sda_oe <= 1'b0;
      end else if (stop_det) begin
        st     <= ST_IDLE;
        sda_oe <= 1'b0;
      end else begin
        case (st)
          ST_RX: begin
            if (scl_rise && cnt != 4'd8) begin
              sh  <= {sh[6:0], sda_q};
              cnt <= cnt + 4'd1;
            end else if (scl_fall && cnt == 4'd8) begin
              case (kind)
                BY_ADDR: begin
                  if (sh[7:1] == DEV_ADDR) begin
                    rw     <= sh[0];
                    sda_oe <= 1'b1;
                    st     <= ST_RX_ACK;
                  end else begin
                    st <= ST_IDLE;
                  end
                end
                BY_SUB: begin
                  test_flag <= sh[7];
                  ai        <= sh[5];
                  idx       <= sh[IDX_W-1:0];
                  sda_oe    <= 1'b1;
                  st        <= ST_RX_ACK;
                end
                default: begin
                  wr_en   <= 1'b1;
                  wr_idx  <= idx;
                  wr_data <= sh;
                  if (ai) idx <= idx + 1'b1;
                  sda_oe  <= 1'b1;
                  st      <= ST_RX_ACK;
                end
              endcase
            end
          end
          ST_RX_ACK: begin
            if (scl_fall) begin
              cnt <= '0;
              if (kind == BY_ADDR && rw) begin
                tx     <= status_byte;
                sda_oe <= ~status_byte[7];
                st     <= ST_TX;
              end else begin
                sda_oe <= 1'b0;
                st     <= ST_RX;
                kind   <= (kind == BY_ADDR) ? BY_SUB : BY_DATA;
              end
            end
          end
          ST_TX: begin
            if (scl_fall) begin
              if (cnt == 4'd7) begin
                sda_oe <= 1'b0;
                st     <= ST_TX_ACK;
              end else begin
                cnt    <= cnt + 4'd1;
                tx     <= {tx[6:0], 1'b0};
                sda_oe <= ~tx[6];
              end
            end
          end
          ST_TX_ACK: begin
            if (scl_rise) begin
              nack <= sda_q;
            end else if (scl_fall) begin
              cnt <= '0;
              if (!nack) begin
                tx     <= status_byte;
                sda_oe <= ~status_byte[7];
                st     <= ST_TX;
              end else begin
                st <= ST_IDLE;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  AST_STOP_RELEASES: assert property (@(posedge clk) disable iff (rst) stop_det |=> !sda_oe) else $error("sda held after stop"); // R10
  AST_DRIVE_PHASE: assert property (@(posedge clk) disable iff (rst) sda_oe |-> (st == ST_RX_ACK || st == ST_TX)) else $error("sda driven outside ack/tx"); // R8
  AST_WRITE_ON_FALL: assert property (@(posedge clk) disable iff (rst) wr_en |-> $past(scl_fall)) else $error("write not tied to scl fall"); // R5
  AST_AI_STEP: assert property (@(posedge clk) disable iff (rst) (wr_en && ai) |-> (idx == wr_idx + 1'b1)) else $error("auto-increment step wrong"); // R3
  AST_NO_AI_HOLD: assert property (@(posedge clk) disable iff (rst) (wr_en && !ai) |-> (idx == wr_idx)) else $error("index moved without auto-increment"); // R4

endmodule

// File: rtl/ctl_i2c_regfile.sv
module ctl_i2c_regfile
  import ctl_i2c_pkg::*;
#(
  parameter int NREG      = 32,
  parameter int TEST_BASE = 27,
  parameter int IDX_W     = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [7:0]        wr_data,
  input  logic              test_flag,
  output logic [NREG*8-1:0] regs_o,
  output logic [NREG-1:0]   wr_stb,
  output logic              fast_chg,
  output logic              test_en
);
  logic [NREG-1:0][7:0] mem;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NREG; i++) mem[i] <= reg_reset_value(i, TEST_BASE);
      wr_stb   <= '0;
      fast_chg <= 1'b1;
      test_en  <= 1'b0;
    end else begin
      wr_stb <= '0;
      for (int i = 0; i < NREG; i++) begin
        if (wr_en && wr_idx == IDX_W'(i)) begin
          mem[i]    <= wr_data;
          wr_stb[i] <= 1'b1;
        end
      end
      if (wr_en && wr_idx == '0) fast_chg <= 1'b0;
      test_en <= test_flag & mem[TEST_BASE][0];
    end
  end

  assign regs_o = mem;

  AST_STB_ONEHOT: assert property (@(posedge clk) disable iff (rst) $onehot0(wr_stb)) else $error("several strobes"); // R5
  AST_FCHG_NO_REARM: assert property (@(posedge clk) disable iff (rst) !$rose(fast_chg)) else $error("fast charge re-armed"); // R7
  AST_HOLD_NO_WRITE: assert property (@(posedge clk) disable iff (rst) !wr_en |=> $stable(mem)) else $error("register changed without write"); // R6

endmodule

// File: rtl/ctl_i2c_target.sv
module ctl_i2c_target #(
  parameter int         NREG        = 32,
  parameter int         TEST_BASE   = 27,
  parameter int         SYNC_STAGES = 2,
  parameter logic [6:0] DEV_ADDR    = 7'b1000100
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe,
  input  logic [5:0]        stat_i,
  output logic [NREG*8-1:0] regs_o,
  output logic [NREG-1:0]   wr_stb_o,
  output logic              fast_chg_o,
  output logic              test_en_o
);
  localparam int IDX_W  = $clog2(NREG);
  localparam int STAT_W = 6;

  logic sda_q, scl_rise, scl_fall, start_det, stop_det;
  logic wr_en, test_flag;
  logic [IDX_W-1:0] wr_idx;
  logic [7:0] wr_data;

  ctl_i2c_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .scl_i(scl_i), .sda_i(sda_i),
    .sda_q(sda_q), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  ctl_i2c_engine #(.DEV_ADDR(DEV_ADDR), .IDX_W(IDX_W), .STAT_W(STAT_W)) u_engine (
    .clk(clk), .rst(rst), .sda_q(sda_q), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det), .stat_i(stat_i),
    .sda_oe(sda_oe), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .test_flag(test_flag)
  );

  ctl_i2c_regfile #(.NREG(NREG), .TEST_BASE(TEST_BASE), .IDX_W(IDX_W)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .test_flag(test_flag), .regs_o(regs_o), .wr_stb(wr_stb_o),
    .fast_chg(fast_chg_o), .test_en(test_en_o)
  );

endmodule

// File: tb/tb_ctl_i2c_target.sv
module tb_ctl_i2c_target;
  localparam int Q = 30;
  localparam int H = 60;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic scl_m = 1'b1;
  logic sda_m = 1'b1;
  logic sda_bus;
  logic sda_oe;
  logic [5:0] stat_i = 6'h00;
  logic [255:0] regs_o;
  logic [31:0] wr_stb_o;
  logic fast_chg_o, test_en_o;

  int checks = 0;
  int fails = 0;
  int stb_cnt = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;
  assign sda_bus = sda_m & ~sda_oe;

  ctl_i2c_target dut (
    .clk(clk), .rst(rst), .scl_i(scl_m), .sda_i(sda_bus), .sda_oe(sda_oe),
    .stat_i(stat_i), .regs_o(regs_o), .wr_stb_o(wr_stb_o),
    .fast_chg_o(fast_chg_o), .test_en_o(test_en_o)
  );

  always @(negedge clk) if (!rst) stb_cnt += $countones(wr_stb_o);

  // {register index, data}, each written with auto-increment clear
  localparam logic [12:0] VEC [8] = '{
    {5'd3, 8'hA5}, {5'd7, 8'h3C}, {5'd12, 8'hFF}, {5'd19, 8'h01},
    {5'd26, 8'h80}, {5'd31, 8'h5A}, {5'd16, 8'hC3}, {5'd3, 8'h0F}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_clks(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic i2c_start();
    sda_m = 1'b1; scl_m = 1'b1; wait_clks(Q);
    sda_m = 1'b0; wait_clks(Q);
    scl_m = 1'b0; wait_clks(Q);
  endtask

  task automatic i2c_stop();
    sda_m = 1'b0; wait_clks(Q);
    scl_m = 1'b1; wait_clks(Q);
    sda_m = 1'b1; wait_clks(Q);
  endtask

  task automatic send_byte(input logic [7:0] b, output bit acked);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; wait_clks(Q);
      scl_m = 1'b1; wait_clks(H);
      scl_m = 1'b0; wait_clks(Q);
    end
    sda_m = 1'b1; wait_clks(Q);
    scl_m = 1'b1; wait_clks(H / 2);
    acked = !sda_bus;
    wait_clks(H / 2);
    scl_m = 1'b0; wait_clks(Q);
  endtask

  task automatic recv_byte(input bit last, output logic [7:0] b);
    for (int i = 7; i >= 0; i--) begin
      sda_m = 1'b1; wait_clks(Q);
      scl_m = 1'b1; wait_clks(H / 2);
      b[i] = sda_bus;
      wait_clks(H / 2);
      scl_m = 1'b0; wait_clks(Q);
    end
    sda_m = last; wait_clks(Q);
    scl_m = 1'b1; wait_clks(H);
    scl_m = 1'b0; wait_clks(Q);
    sda_m = 1'b1;
  endtask

  // Write n bytes from data (MSB byte first); returns number of acks seen
  task automatic do_write(input logic [7:0] sub, input logic [23:0] data, input int n, output int acks);
    bit a;
    acks = 0;
    i2c_start();
    send_byte(8'h88, a); acks += int'(a);
    send_byte(sub, a);   acks += int'(a);
    for (int k = 0; k < n; k++) begin
      send_byte(data[23-8*k -: 8], a); acks += int'(a);
    end
    i2c_stop();
    wait_clks(4);
  endtask

  function automatic logic [7:0] rg(input int n);
    return regs_o[n*8 +: 8];
  endfunction

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin : main
    int acks;
    bit a;
    logic [7:0] rb;
    wait_clks(10);
    rst = 1'b0;
    wait_clks(5);

    // R6 reset values
    for (int k = 0; k < 32; k++) chk("R6 reset value", rg(k), (k >= 27) ? 8'hFE : 8'h00);
    chk("R7 fast charge after reset", fast_chg_o, 1);
    chk("R9 test enable after reset", test_en_o, 0);
    chk("R10 sda released after reset", sda_oe, 0);

    // R1 foreign address: no ack, register 0 and fast charge untouched
    i2c_start();
    send_byte(8'h8A, a);
    chk("R1 foreign address nacked", a, 0);
    send_byte(8'h00, a);
    send_byte(8'h99, a);
    chk("R1 foreign data nacked", a, 0);
    i2c_stop();
    wait_clks(4);
    chk("R1 reg0 unchanged", rg(0), 8'h00);
    chk("R7 fast charge kept", fast_chg_o, 1);

    // R2 table of single writes
    for (int k = 0; k < 8; k++) begin
      do_write({3'b000, VEC[k][12:8]}, {VEC[k][7:0], 16'h0}, 1, acks);
      chk("R1 R2 all bytes acked", acks, 3);
      chk("R2 register stored", rg(int'(VEC[k][12:8])), VEC[k][7:0]);
    end
    chk("R2 reg3 last write kept", rg(3), 8'h0F);

    // R3 auto-increment wrap 30,31,0 and R5 strobes, R7 release
    stb_cnt = 0;
    do_write(8'h20 | 8'd30, 24'h112233, 3, acks);
    chk("R3 acks", acks, 5);
    chk("R3 reg30", rg(30), 8'h11);
    chk("R3 reg31", rg(31), 8'h22);
    chk("R3 wrap to reg0", rg(0), 8'h33);
    chk("R5 one-cycle strobe per byte", stb_cnt, 3);
    chk("R7 fast charge released", fast_chg_o, 0);

    // R4 no auto-increment: same register overwritten
    stb_cnt = 0;
    do_write(8'h05, 24'h445566, 3, acks);
    chk("R4 last byte kept", rg(5), 8'h66);
    chk("R4 neighbour untouched", rg(6), 8'h00);
    chk("R5 strobe count", stb_cnt, 3);
    chk("R7 fast charge stays low", fast_chg_o, 0);

    // R9 test enable combination
    do_write(8'h80 | 8'd27, 24'hFF0000, 1, acks);
    chk("R9 flag and bit set", test_en_o, 1);
    do_write(8'd27, 24'hFF0000, 1, acks);
    chk("R9 flag clear", test_en_o, 0);
    do_write(8'h80 | 8'd4, 24'h000000, 1, acks);
    chk("R9 flag set bit still set", test_en_o, 1);
    do_write(8'h80 | 8'd27, 24'hFE0000, 1, acks);
    chk("R9 bit0 clear", test_en_o, 0);

    // R8 status read with refresh after ack
    stat_i = 6'b101101;
    i2c_start();
    send_byte(8'h89, a);
    chk("R8 read address acked", a, 1);
    stat_i = 6'b010010;
    recv_byte(1'b0, rb);
    chk("R8 first status byte", rb, 8'h2D);
    recv_byte(1'b1, rb);
    chk("R8 refreshed status byte", rb, 8'h12);
    wait_clks(4);
    chk("R8 released after nack", sda_oe, 0);
    i2c_stop();
    wait_clks(4);
    chk("R10 released after stop", sda_oe, 0);

    // R10 repeated start inside a write
    i2c_start();
    send_byte(8'h88, a);
    send_byte(8'd9, a);
    send_byte(8'h77, a);
    i2c_start();
    send_byte(8'h88, a);
    chk("R10 address after repeated start", a, 1);
    send_byte(8'd10, a);
    send_byte(8'h88, a);
    i2c_stop();
    wait_clks(4);
    chk("R10 first part stored", rg(9), 8'h77);
    chk("R10 second part stored", rg(10), 8'h88);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule